// File: doc/BRIEF.md
# Dual-Mode ADC Serial Slave

This block is the digital side of a 12-bit serial converter, written as a synthesizable slave for exercising host controllers. A single active-low pin, `cs_n`, acts as the conversion strobe in mode 0 and as chip select in mode 1. The host supplies the serial clock `sclk`, and a parallel `sample` input stands in for the analog result. Each result is sent as a 16-bit word, MSB first: four zero bits, then the 12-bit value. The data pin is modelled as `sdo` plus an output enable `sdo_oe`.

In mode 0, a strobe falling edge starts a timed conversion. When the conversion ends, the result is loaded, and the host reads it with 16 clocks. In mode 1, each chip-select frame converts and shifts out at once, and a frame that ends inside a set window of clock counts puts the slave to sleep. The slave picks its mode from pin activity alone:

- Clocking during a mode-0 conversion while the strobe is low moves it to mode 1.
- A frame with no clock at all moves it back to mode 0.

All pins are sampled by the system clock `clk`, and each edge is detected against the value from the previous cycle.

Top module: `adc_serial_slave`

## Requirements
- R1: After reset the slave is in mode 0 (`mode`=0), awake (`pwr_dn`=0), with `sdo_oe`=0 and `sdo`=0.
- R2: In mode 0, a `cs_n` falling edge latches `sample` and starts a conversion of CLK_MHZ*CONV_NS/1000 clock cycles (825 by default). At its end the output word {4'b0000, sample} is loaded. During a read, the first `sclk` rise drives word bit 15, and after n `sclk` falls the line presents bit 15-n.
- R3: In mode 0, the 16th `sclk` fall of a read returns the counter to zero and drops `sdo_oe`. Further clocks restart the shift-out from bit 15, and after that second pass `sdo_oe` stays high through the 16th fall and beyond.
- R4: In mode 0, a `cs_n` falling edge clears the bit counter and `sdo_oe` only while `sclk` is low. With `sclk` high, the counter and the enable keep their values.
- R5: In mode 0, any `sclk` edge during a conversion while `cs_n` is low switches the slave to mode 1 and abandons that conversion. `sclk` edges while `cs_n` is high during a conversion have no effect.
- R6: In mode 1, a `cs_n` falling edge latches `sample` and drives bit 15 of {4'b0000, sample}. After n `sclk` falls the line presents bit 15-n. `sdo_oe` drops on the 16th fall, or on a `cs_n` rise if that comes first.
- R7: In mode 1 while awake, a `cs_n` low-then-high pulse with no `sclk` edge returns the slave to mode 0.
- R8: In mode 1 while awake, a `cs_n` rise after 2 to 9 `sclk` falls (PD_LO to PD_HI-1) enters power-down. Any other count leaves `pwr_dn` at 0.
- R9: While powered down, a `cs_n` rise after 11 or more `sclk` falls (WAKE_MIN) wakes the slave. Fewer falls, including none, leave it asleep and in mode 1.
- R10: A mode-1 frame started while powered down shifts out all zeros.
- R11: Power-down is only ever set while the slave is in mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Conversion strobe (mode 0) or chip select (mode 1), active low |
| sclk | input | 1 | Serial clock from the host |
| sample | input | 12 | Parallel value taken as the conversion result |
| sdo | output | 1 | Serial data bit, 0 while not enabled |
| sdo_oe | output | 1 | Drive enable of the data line; low means the line floats |
| mode | output | 1 | Current operating mode: 0 internal-clock, 1 external-clock |
| pwr_dn | output | 1 | High while the slave is powered down |

## Verification
Mode-0 reads are swept over these samples:

- all zeros and all ones, which would hide a stuck enable or a stuck data level;
- alternating patterns, which show bit-order or off-by-one shifts;
- single-bit-set values, which pin down the MSB-first alignment after the four leading zeros.

A double read and a strobe edge taken with the clock high tell wrap-and-redrive behaviour apart from counter reset behaviour. The mode-1 frame length is swept from 0 to 16 falls, both awake and asleep. This sweep places the exact edges of the sleep window, the wake threshold and the clockless return to mode 0, and a frame started while asleep shows the zeroed output.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
  localparam int RES_W  = 12;
  localparam int WORD_W = 16;
  localparam int LEAD_W = WORD_W - RES_W;
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int CNT_W  = IDX_W + 1;
endpackage

// File: rtl/adcs_edge.sv
module adcs_edge #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= din;
  end

  for (genvar i = 0; i < W; i++) begin : g_det
    assign rise[i] = din[i] & ~prev_q[i];
    assign fall[i] = ~din[i] & prev_q[i];
  end
endmodule

// File: rtl/adcs_conv.sv
module adcs_conv #(
  parameter int CYCLES = 825
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done   = 1'b0;
    if (abort) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        done   = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = CW'(CYCLES - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

  // R2: a conversion at its last count always finishes on the next edge
  a_r2_conv_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == '0 && !abort) |=> !busy_q);

  // R5: an abort ends the conversion without a completion
  a_r5_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy_q);
endmodule

// File: rtl/adcs_shift.sv
module adcs_shift
  import adcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode1,
  input  logic              cs_low,
  input  logic              sclk_lvl,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              busy,
  input  logic              swap,
  input  logic [WORD_W-1:0] word,
  output logic              sdo,
  output logic              oe,
  output logic [CNT_W-1:0]  cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             oe_q, oe_d;
  logic             again_q, again_d;
  logic [IDX_W-1:0] idx;

  always_comb begin
    cnt_d   = cnt_q;
    oe_d    = oe_q;
    again_d = again_q;
    if (!mode1) begin
      if (swap || (cs_fall && !sclk_lvl)) begin
        cnt_d   = '0;
        oe_d    = 1'b0;
        again_d = 1'b0;
      end else if (!busy) begin
        if (sclk_rise && !oe_q) oe_d = 1'b1;
        if (sclk_fall && oe_q) begin
          if (cnt_q == CNT_W'(WORD_W - 1)) begin
            cnt_d = '0;
            if (!again_q) begin
              oe_d    = 1'b0;
              again_d = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
    end else begin
      if (cs_fall) begin
        cnt_d   = '0;
        oe_d    = 1'b1;
        again_d = 1'b0;
      end else if (cs_rise) begin
        oe_d = 1'b0;
      end else if (cs_low && sclk_fall && cnt_q < CNT_W'(WORD_W)) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(WORD_W - 1)) oe_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      oe_q    <= 1'b0;
      again_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      oe_q    <= oe_d;
      again_q <= again_d;
    end
  end

  assign idx = IDX_W'(WORD_W - 1) - cnt_q[IDX_W-1:0];
  assign sdo = oe_q & word[idx];
  assign oe  = oe_q;
  assign cnt = cnt_q;

  // R6: selecting the slave in mode 1 drives the line on the next cycle
  a_r6_drive_on_select: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1 && cs_fall) |=> oe_q);

  // R6: the 16th fall of a mode-1 frame floats the line
  a_r6_float_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1 && !cs_fall && !cs_rise && cs_low && sclk_fall && cnt_q == CNT_W'(WORD_W - 1)) |=> !oe_q);

  // R3: the bit counter never passes the word length
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WORD_W));
endmodule

// File: rtl/adc_serial_slave.sv
module adc_serial_slave
  import adcs_pkg::*;
#(
  parameter int CLK_MHZ  = 250,
  parameter int CONV_NS  = 3300,
  parameter int PD_LO    = 2,
  parameter int PD_HI    = 10,
  parameter int WAKE_MIN = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic [RES_W-1:0] sample,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             mode,
  output logic             pwr_dn
);
  localparam int CONV_CYCLES = CLK_MHZ * CONV_NS / 1000;

  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic [1:0] ev_rise, ev_fall;
  logic       cs_fall, cs_rise, sclk_rise, sclk_fall, sclk_any;

  adcs_edge #(.W(2), .RST_VAL(2'b01)) i_edge (
    .clk (clk),
    .rst_n (rst_i),
    .din ({sclk, cs_n}),
    .rise (ev_rise),
    .fall (ev_fall)
  );

  assign cs_fall   = ev_fall[0];
  assign cs_rise   = ev_rise[0];
  assign sclk_rise = ev_rise[1];
  assign sclk_fall = ev_fall[1];
  assign sclk_any  = sclk_rise | sclk_fall;

  logic mode_q, mode_d, pd_q, pd_d, seen_q, seen_d;
  logic busy, done, start, swap;
  logic [RES_W-1:0]  hold_q, hold_d, out_q, out_d;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] word;

  assign start = !mode_q && cs_fall && !busy;
  assign swap  = !mode_q && busy && !cs_n && sclk_any;

  adcs_conv #(.CYCLES(CONV_CYCLES)) i_conv (
    .clk (clk),
    .rst_n (rst_i),
    .start (start),
    .abort (swap),
    .busy (busy),
    .done (done)
  );

  assign word = {{LEAD_W{1'b0}}, out_q};

  adcs_shift i_shift (
    .clk (clk),
    .rst_n (rst_i),
    .mode1 (mode_q),
    .cs_low (!cs_n),
    .sclk_lvl (sclk),
    .cs_fall (cs_fall),
    .cs_rise (cs_rise),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .busy (busy),
    .swap (swap),
    .word (word),
    .sdo (sdo),
    .oe (sdo_oe),
    .cnt (bit_cnt)
  );

  always_comb begin
    mode_d = mode_q;
    pd_d   = pd_q;
    seen_d = seen_q;
    hold_d = hold_q;
    out_d  = out_q;
    if (start) hold_d = sample;
    if (done)  out_d  = hold_q;
    if (swap) begin
      mode_d = 1'b1;
      seen_d = 1'b1;
    end else if (mode_q) begin
      if (cs_fall) begin
        seen_d = 1'b0;
        out_d  = pd_q ? '0 : sample;
      end else if (cs_rise) begin
        if (pd_q) begin
          if (bit_cnt >= CNT_W'(WAKE_MIN)) pd_d = 1'b0;
        end else if (!seen_q) begin
          mode_d = 1'b0;
        end else if (bit_cnt >= CNT_W'(PD_LO) && bit_cnt < CNT_W'(PD_HI)) begin
          pd_d = 1'b1;
        end
      end else if (!cs_n && sclk_any) begin
        seen_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      mode_q <= 1'b0;
      pd_q   <= 1'b0;
      seen_q <= 1'b0;
      hold_q <= '0;
      out_q  <= '0;
    end else begin
      mode_q <= mode_d;
      pd_q   <= pd_d;
      seen_q <= seen_d;
      hold_q <= hold_d;
      out_q  <= out_d;
    end
  end

  assign mode   = mode_q;
  assign pwr_dn = pd_q;

  // R11: sleeping implies external-clock mode
  a_r11_sleep_in_m1: assert property (@(posedge clk) disable iff (!rst_i)
    pd_q |-> mode_q);

  // R5: clocking a mode-0 conversion with the strobe low lands in mode 1
  a_r5_switch: assert property (@(posedge clk) disable iff (!rst_i)
    (!mode_q && busy && !cs_n && sclk_any) |=> mode_q);

  // R8: sleep is only entered at a chip-select rise
  a_r8_sleep_at_rise: assert property (@(posedge clk) disable iff (!rst_i)
    (!pd_q && pd_d) |-> cs_rise);

  // R9: waking also happens only at a chip-select rise
  a_r9_wake_at_rise: assert property (@(posedge clk) disable iff (!rst_i)
    (pd_q && !pd_d) |-> cs_rise);
endmodule

// File: tb/test_adc_serial_slave.sv
module test_adc_serial_slave;
  localparam int CONV = 250 * 3300 / 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic [11:0] sample = '0;
  logic        sdo, sdo_oe, mode, pwr_dn;

  int errs = 0;
  int checks = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  adc_serial_slave i_adc_serial_slave (
    .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sclk (sclk),
    .sample (sample), .sdo (sdo), .sdo_oe (sdo_oe),
    .mode (mode), .pwr_dn (pwr_dn)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_sclk(input logic v);
    sclk = v;
    idle(2);
  endtask

  task automatic set_cs(input logic v);
    cs_n = v;
    idle(2);
  endtask

  task automatic m0_convert(input logic [11:0] s);
    sample = s;
    set_cs(1'b0);
    set_cs(1'b1);
    idle(CONV + 4);
  endtask

  task automatic m0_read(input logic [15:0] w, input string req);
    for (int i = 0; i < 16; i++) begin
      set_sclk(1'b1);
      chk(req, sdo_oe, 1'b1);
      chk(req, sdo, w[15-i]);
      set_sclk(1'b0);
    end
  endtask

  task automatic to_mode1();
    sample = 12'h111;
    set_cs(1'b0);
    idle(3);
    set_sclk(1'b1);
    chk("R5 switch", mode, 1'b1);
    set_sclk(1'b0);
    set_cs(1'b1);
    chk("R5 stays m1", mode, 1'b1);
    chk("R5 awake", pwr_dn, 1'b0);
  endtask

  task automatic m1_frame(input logic [11:0] s, input int k, input bit dchk,
                          input logic [15:0] w, input string req);
    sample = s;
    set_cs(1'b0);
    if (dchk) begin
      chk(req, sdo_oe, 1'b1);
      chk(req, sdo, w[15]);
    end
    for (int i = 1; i <= k; i++) begin
      set_sclk(1'b1);
      set_sclk(1'b0);
      if (dchk) begin
        if (i < 16) begin
          chk(req, sdo_oe, 1'b1);
          chk(req, sdo, w[15-i]);
        end else begin
          chk(req, sdo_oe, 1'b0);
        end
      end
    end
    set_cs(1'b1);
    chk(req, sdo_oe, 1'b0);
  endtask

  initial begin
    logic [11:0] pats [8];
    pats = '{12'h000, 12'hFFF, 12'hA5A, 12'h5A5, 12'h800, 12'h001, 12'h7FE, 12'h3C7};

    idle(5);
    rst_n = 1'b1;
    idle(5);
    // R1 reset state
    chk("R1 mode", mode, 1'b0);
    chk("R1 pwr_dn", pwr_dn, 1'b0);
    chk("R1 oe", sdo_oe, 1'b0);
    chk("R1 sdo", sdo, 1'b0);

    // R2 mode-0 conversion and read over the pattern set
    foreach (pats[j]) begin
      m0_convert(pats[j]);
      chk("R2 oe before read", sdo_oe, 1'b0);
      m0_read({4'b0000, pats[j]}, "R2 read");
      chk("R3 float after 16", sdo_oe, 1'b0);
      chk("R2 mode", mode, 1'b0);
    end

    // R3 extra clocks restart and keep the line driven
    m0_read({4'b0000, pats[7]}, "R3 reread");
    chk("R3 stays driven", sdo_oe, 1'b1);
    chk("R3 back at msb", sdo, 1'b0);

    // R4 strobe fall with sclk low clears the enable
    sample = 12'hB6D;
    set_cs(1'b0);
    chk("R4 cleared", sdo_oe, 1'b0);
    set_cs(1'b1);
    idle(CONV + 4);

    // R4 strobe fall with sclk high keeps the count
    for (int i = 0; i < 5; i++) begin
      set_sclk(1'b1);
      set_sclk(1'b0);
    end
    set_sclk(1'b1);
    chk("R4 mid read", sdo, 1'(12'hB6D >> 10));
    sample = 12'h9E1;
    set_cs(1'b0);
    chk("R4 kept oe", sdo_oe, 1'b1);
    set_cs(1'b1);
    set_sclk(1'b0);
    chk("R5 no switch strobe high", mode, 1'b0);
    idle(CONV + 4);
    chk("R4 kept count", sdo, 1'(16'h09E1 >> 10));
    chk("R4 kept oe after", sdo_oe, 1'b1);

    // clean start again
    m0_convert(12'h4D2);
    m0_read({4'b0000, 12'h4D2}, "R4 recovered read");

    // R5 mode switch
    to_mode1();

    // R6 mode-1 frames
    m1_frame(12'hC3A, 16, 1'b1, {4'b0000, 12'hC3A}, "R6 frame");
    m1_frame(12'h0F0, 16, 1'b1, {4'b0000, 12'h0F0}, "R6 frame");
    m1_frame(12'hFFF, 16, 1'b1, {4'b0000, 12'hFFF}, "R6 frame");
    m1_frame(12'h6B9, 12, 1'b1, {4'b0000, 12'h6B9}, "R6 early rise");
    chk("R8 no sleep at 12", pwr_dn, 1'b0);
    chk("R6 mode", mode, 1'b1);

    // R7 clockless pulse returns to mode 0
    m1_frame(12'h000, 0, 1'b0, 16'h0, "R7 pulse");
    chk("R7 mode0", mode, 1'b0);
    to_mode1();

    // R8 sweep of frame length while awake
    for (int k = 1; k <= 16; k++) begin
      m1_frame(12'h2AA, k, 1'b0, 16'h0, "R8 sweep");
      chk($sformatf("R8 sleep k=%0d", k), pwr_dn, 1'((k >= 2) && (k < 10)));
      chk($sformatf("R8 mode k=%0d", k), mode, 1'b1);
      if (pwr_dn) begin
        m1_frame(12'hFFF, 16, 1'b1, 16'h0000, "R10 zero frame");
        chk("R9 woke", pwr_dn, 1'b0);
      end
    end

    // R9 sweep of wake frame length while asleep
    m1_frame(12'h000, 5, 1'b0, 16'h0, "R8 enter");
    chk("R8 asleep", pwr_dn, 1'b1);
    for (int k = 0; k <= 16; k++) begin
      m1_frame(12'h555, k, 1'b0, 16'h0, "R9 sweep");
      chk($sformatf("R9 sleep k=%0d", k), pwr_dn, 1'(k < 11));
      chk($sformatf("R9 mode k=%0d", k), mode, 1'b1);
      if (!pwr_dn && k < 16) begin
        m1_frame(12'h000, 5, 1'b0, 16'h0, "R8 reenter");
        chk("R8 reenter", pwr_dn, 1'b1);
      end
    end

    // awake again: data valid
    m1_frame(12'h8E3, 16, 1'b1, {4'b0000, 12'h8E3}, "R10 valid after wake");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule